// File: doc/BRIEF.md
# Channel Address Compactor

This block converts a system physical address into a dense address local to one memory channel. A bank of eight target-range entries is held on configuration inputs. Each entry describes an address window, a socket interleave, a channel interleave and a per-channel offset. When a request arrives, the block finds the entry whose window holds the address and subtracts the offset that belongs to the requesting channel. It then squeezes the socket and channel interleave out of the result, which gives a contiguous address for that channel.

Each squeeze step divides the part of the address above an interleave granularity by a way count and keeps the bits below that granularity. Way counts may be 1, 2, 3, 4 or 8. Because three-way channel interleave exists, the block needs a real divider: a radix-2 iterative unit. The two steps run one after the other through that divider. A request is accepted only while the block is idle. Each request yields exactly one result pulse that carries the address, the two way counts and a miss flag.

Top module: `chan_addr_compactor`

## Requirements
- R1: An entry covers the addresses from its window base up to and including its window limit. The base is base-word bits [31:12] placed at address bit 26 with zeros below. The limit is way-word bits [31:12] placed at bit 26 with ones below. If several entries cover the address, the one with the lowest index is used.
- R2: On a hit, the reported socket way count is 1 shifted left by way-word bits [11:10]. The reported channel way count is way-word bits [9:8] plus one.
- R3: Base-word bits [5:4] select the socket granularity and base-word bits [7:6] select the channel granularity. Codes 0, 1, 2 and 3 mean address bits 6, 8, 12 and 30.
- R4: The offset word is chosen by the entry and by the request's channel number (0 to 2). Its bits [23:4], placed at address bit 26, are subtracted from the system address modulo 2^46 before any squeeze step.
- R5: A squeeze step with granularity g, way count w and a low-bit source L gives ((x >> g) / w) << g, with bits below g taken from L.
- R6: When the channel way count is 3 and the socket granularity bit is strictly higher than the channel granularity bit, the channel step runs first on the offset-reduced address and takes its low bits from that address. The socket step then runs on the result and takes its low bits from that result.
- R7: In every other case, the socket step runs first and the channel step runs on its result. Both steps take their low bits from the original system address.
- R8: When no entry covers the address, the result pulse has the miss flag set, with a zero address and zero way counts.
- R9: in_ready_o is high only while the block is idle. Each accepted request gives exactly one single-cycle out_valid_o pulse, in request order. Requests presented while in_ready_o is low are ignored and produce no result.
- R10: Division is exact for every 46-bit dividend, including division by 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base_i | input | 8x32 | Per-entry base word: window base and granularity codes |
| cfg_way_i | input | 8x32 | Per-entry way word: window limit and way-count codes |
| cfg_off_i | input | 8x3x32 | Per-entry, per-channel offset word |
| in_valid_i | input | 1 | Request present |
| in_addr_i | input | 46 | System address of the request |
| in_chan_i | input | 2 | Channel number of the request |
| in_ready_o | output | 1 | Block idle and able to take a request |
| out_valid_o | output | 1 | Single-cycle result strobe |
| out_miss_o | output | 1 | No entry covered the address |
| out_addr_o | output | 46 | Compacted channel address |
| out_sock_ways_o | output | 4 | Socket way count of the hit entry |
| out_chan_ways_o | output | 3 | Channel way count of the hit entry |

## Verification
The case that is hardest to reach from the ports is the channel-first ordering. It appears only when a hit entry combines three channel ways with a socket granularity strictly above the channel granularity. A neighbouring entry with three ways and equal granularities must still take the socket-first path. The stimulus loads entries that sit on both sides of this condition, and it uses non-zero offsets and addresses whose low bits differ between the raw and the offset-reduced address. Ignored requests are reached by holding in_valid_i high with unrelated addresses while a division is in progress; the scoreboard then sees any extra result pulse.

// File: rtl/cac_pkg.sv
package cac_pkg;
    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 20;
    localparam int LOW_W    = 26;
    localparam int ADDR_W   = FIELD_W + LOW_W;
    localparam int FIELD_LO = WORD_W - FIELD_W;
    localparam int GRAN_W   = 5;
    localparam int SWAY_W   = 4;
    localparam int CWAY_W   = 3;
    localparam int DSR_W    = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP1 = 2'd1,
        ST_STEP2 = 2'd2,
        ST_FIN   = 2'd3
    } cac_state_e;

    // granularity code -> address bit position
    function automatic logic [GRAN_W-1:0] gran_pos(input logic [1:0] code);
        case (code)
            2'd0:    return GRAN_W'(6);
            2'd1:    return GRAN_W'(8);
            2'd2:    return GRAN_W'(12);
            default: return GRAN_W'(30);
        endcase
    endfunction
endpackage

// File: rtl/cac_range_match.sv
module cac_range_match
    import cac_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [ENTRIES-1:0][WORD_W-1:0] base_w_i,
    input  logic [ENTRIES-1:0][WORD_W-1:0] way_w_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               idx_o
);
    logic [ENTRIES-1:0] in_win;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic [ADDR_W-1:0] win_lo;
        logic [ADDR_W-1:0] win_hi;
        logic              unused_low;
        assign win_lo     = {base_w_i[i][WORD_W-1:FIELD_LO], {LOW_W{1'b0}}};
        assign win_hi     = {way_w_i[i][WORD_W-1:FIELD_LO], {LOW_W{1'b1}}};
        assign in_win[i]  = (addr_i >= win_lo) && (addr_i <= win_hi);
        assign unused_low = ^{base_w_i[i][FIELD_LO-1:0], way_w_i[i][FIELD_LO-1:0]};
    end

    // lowest index wins
    always_comb begin
        hit_o = |in_win;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (in_win[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cac_divider.sv
module cac_divider
    import cac_pkg::*;
#(
    parameter int DW = ADDR_W,
    localparam int CNT_W = $clog2(DW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DW-1:0]    dividend_i,
    input  logic [DSR_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DW-1:0]    quot_o
);
    typedef struct packed {
        logic [DW-1:0]    quo;
        logic [DW-1:0]    dvd;
        logic [DSR_W-1:0] rem;
        logic [DSR_W-1:0] dsr;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } div_st_t;

    div_st_t div_d, div_q;
    logic [DSR_W:0] trial;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = {div_q.rem, div_q.quo[DW-1]};
        if (start_i) begin
            div_d.quo  = dividend_i;
            div_d.dvd  = dividend_i;
            div_d.rem  = '0;
            div_d.dsr  = divisor_i;
            div_d.cnt  = CNT_W'(DW);
            div_d.busy = 1'b1;
        end else if (div_q.busy) begin
            if (trial >= {1'b0, div_q.dsr}) begin
                div_d.rem = DSR_W'(trial - {1'b0, div_q.dsr});
                div_d.quo = {div_q.quo[DW-2:0], 1'b1};
            end else begin
                div_d.rem = trial[DSR_W-1:0];
                div_d.quo = {div_q.quo[DW-2:0], 1'b0};
            end
            div_d.cnt = div_q.cnt - CNT_W'(1);
            if (div_q.cnt == CNT_W'(1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done_o = div_q.done;
    assign quot_o = div_q.quo;

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.done |-> ((64'(div_q.quo) * 64'(div_q.dsr) + 64'(div_q.rem)) == 64'(div_q.dvd))
                       && (div_q.rem < div_q.dsr)); // R10
    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (divisor_i != '0)); // R5
endmodule

// File: rtl/chan_addr_compactor.sv
module chan_addr_compactor
    import cac_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CHANS   = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CH_W   = (CHANS > 1) ? $clog2(CHANS) : 1
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [ENTRIES-1:0][WORD_W-1:0]            cfg_base_i,
    input  logic [ENTRIES-1:0][WORD_W-1:0]            cfg_way_i,
    input  logic [ENTRIES-1:0][CHANS-1:0][WORD_W-1:0] cfg_off_i,
    input  logic                                      in_valid_i,
    input  logic [ADDR_W-1:0]                         in_addr_i,
    input  logic [CH_W-1:0]                           in_chan_i,
    output logic                                      in_ready_o,
    output logic                                      out_valid_o,
    output logic                                      out_miss_o,
    output logic [ADDR_W-1:0]                         out_addr_o,
    output logic [SWAY_W-1:0]                         out_sock_ways_o,
    output logic [CWAY_W-1:0]                         out_chan_ways_o
);
    typedef struct packed {
        cac_state_e        st;
        logic              div_go;
        logic              chan_first;
        logic [ADDR_W-1:0] sys_addr;
        logic [ADDR_W-1:0] cur_addr;
        logic [GRAN_W-1:0] sg;
        logic [GRAN_W-1:0] cg;
        logic [SWAY_W-1:0] sw;
        logic [CWAY_W-1:0] cw;
        logic              out_valid;
        logic              out_miss;
        logic [ADDR_W-1:0] out_addr;
        logic [SWAY_W-1:0] out_sw;
        logic [CWAY_W-1:0] out_cw;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [WORD_W-1:0] sel_base, sel_way, off_word;
    logic [ADDR_W-1:0] off_amt;
    logic              step_is_chan;
    logic [GRAN_W-1:0] g_sel;
    logic [DSR_W-1:0]  w_sel;
    logic [ADDR_W-1:0] low_src, low_mask, step_res;
    logic [ADDR_W-1:0] div_quot;
    logic              div_done;
    logic              unused_cfg;

    cac_range_match #(.ENTRIES(ENTRIES)) u_match (
        .addr_i   (in_addr_i),
        .base_w_i (cfg_base_i),
        .way_w_i  (cfg_way_i),
        .hit_o    (hit),
        .idx_o    (hit_idx)
    );

    assign sel_base = cfg_base_i[hit_idx];
    assign sel_way  = cfg_way_i[hit_idx];

    always_comb begin
        off_word = '0;
        for (int c = 0; c < CHANS; c++) begin
            if (in_chan_i == CH_W'(c)) off_word = cfg_off_i[hit_idx][c];
        end
    end

    assign off_amt    = {off_word[FIELD_W+3:4], {LOW_W{1'b0}}};
    assign unused_cfg = ^{sel_base[WORD_W-1:8], sel_base[3:0], sel_way[WORD_W-1:12],
                          sel_way[7:0], off_word[WORD_W-1:FIELD_W+4], off_word[3:0]};

    // step operands: channel step is first exactly when chan_first is set
    assign step_is_chan = (ctl_q.st == ST_STEP1) == ctl_q.chan_first;
    assign g_sel        = step_is_chan ? ctl_q.cg : ctl_q.sg;
    assign w_sel        = step_is_chan ? DSR_W'(ctl_q.cw) : ctl_q.sw;
    assign low_src      = ctl_q.chan_first ? ctl_q.cur_addr : ctl_q.sys_addr;
    assign low_mask     = (ADDR_W'(1) << g_sel) - ADDR_W'(1);
    assign step_res     = (div_quot << g_sel) | (low_src & low_mask);

    cac_divider #(.DW(ADDR_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (ctl_q.div_go),
        .dividend_i (ctl_q.cur_addr >> g_sel),
        .divisor_i  (w_sel),
        .done_o     (div_done),
        .quot_o     (div_quot)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.div_go    = 1'b0;
        ctl_d.out_valid = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (in_valid_i) begin
                    if (hit) begin
                        ctl_d.st         = ST_STEP1;
                        ctl_d.div_go     = 1'b1;
                        ctl_d.sys_addr   = in_addr_i;
                        ctl_d.cur_addr   = in_addr_i - off_amt;
                        ctl_d.sg         = gran_pos(sel_base[5:4]);
                        ctl_d.cg         = gran_pos(sel_base[7:6]);
                        ctl_d.sw         = SWAY_W'(1) << sel_way[11:10];
                        ctl_d.cw         = CWAY_W'(sel_way[9:8]) + CWAY_W'(1);
                        ctl_d.chan_first = (sel_way[9:8] == 2'd2) &&
                                           (gran_pos(sel_base[5:4]) > gran_pos(sel_base[7:6]));
                    end else begin
                        ctl_d.st        = ST_FIN;
                        ctl_d.out_valid = 1'b1;
                        ctl_d.out_miss  = 1'b1;
                        ctl_d.out_addr  = '0;
                        ctl_d.out_sw    = '0;
                        ctl_d.out_cw    = '0;
                    end
                end
            end
            ST_STEP1: begin
                if (div_done) begin
                    ctl_d.cur_addr = step_res;
                    ctl_d.st       = ST_STEP2;
                    ctl_d.div_go   = 1'b1;
                end
            end
            ST_STEP2: begin
                if (div_done) begin
                    ctl_d.st        = ST_FIN;
                    ctl_d.out_valid = 1'b1;
                    ctl_d.out_miss  = 1'b0;
                    ctl_d.out_addr  = step_res;
                    ctl_d.out_sw    = ctl_q.sw;
                    ctl_d.out_cw    = ctl_q.cw;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign in_ready_o      = (ctl_q.st == ST_IDLE);
    assign out_valid_o     = ctl_q.out_valid;
    assign out_miss_o      = ctl_q.out_miss;
    assign out_addr_o      = ctl_q.out_addr;
    assign out_sock_ways_o = ctl_q.out_sw;
    assign out_chan_ways_o = ctl_q.out_cw;

    AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_miss_o) |-> (out_addr_o == '0 && out_sock_ways_o == '0
                                         && out_chan_ways_o == '0)); // R8
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> !in_ready_o); // R9
    AST_WAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_miss_o) |-> ($countones(out_sock_ways_o) == 1
                                          && out_chan_ways_o >= CWAY_W'(1)
                                          && out_chan_ways_o <= CWAY_W'(4))); // R2
endmodule

// File: tb/chan_addr_compactor_test.sv
`timescale 1ns/1ps
module chan_addr_compactor_test;
    import cac_pkg::*;
    localparam int ENTRIES = 8;
    localparam int CHANS   = 3;
    localparam longint unsigned AMASK = (64'd1 << ADDR_W) - 1;

    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;

    logic [ENTRIES-1:0][31:0]            cfg_base, cfg_way;
    logic [ENTRIES-1:0][CHANS-1:0][31:0] cfg_off;
    logic              in_valid;
    logic [ADDR_W-1:0] in_addr;
    logic [1:0]        in_chan;
    logic              in_ready, out_valid, out_miss;
    logic [ADDR_W-1:0] out_addr;
    logic [3:0]        out_sw;
    logic [2:0]        out_cw;

    chan_addr_compactor #(.ENTRIES(ENTRIES), .CHANS(CHANS)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_base_i(cfg_base), .cfg_way_i(cfg_way),
        .cfg_off_i(cfg_off), .in_valid_i(in_valid), .in_addr_i(in_addr),
        .in_chan_i(in_chan), .in_ready_o(in_ready), .out_valid_o(out_valid),
        .out_miss_o(out_miss), .out_addr_o(out_addr), .out_sock_ways_o(out_sw),
        .out_chan_ways_o(out_cw)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic              miss;
        logic [3:0]        sw;
        logic [2:0]        cw;
        string             tag;
    } exp_t;

    exp_t sb[$];
    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int gpos(input logic [1:0] c);
        case (c)
            2'd0: return 6;
            2'd1: return 8;
            2'd2: return 12;
            default: return 30;
        endcase
    endfunction

    function automatic longint unsigned squeeze(input longint unsigned x, input int g,
                                                input int w, input longint unsigned low);
        longint unsigned m = (64'd1 << g) - 1;
        return ((((x >> g) / longint'(w)) << g) | (low & m)) & AMASK;
    endfunction

    function automatic exp_t predict(input logic [ADDR_W-1:0] a, input int ch, input string tag);
        exp_t e;
        longint unsigned lo, hi, ca, t, r, off;
        int k = 0, sg, cg, sw, cw;
        bit found = 0;
        e.tag = tag; e.miss = 1'b1; e.addr = '0; e.sw = '0; e.cw = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            lo = longint'(cfg_base[i][31:12]) << 26;
            hi = (longint'(cfg_way[i][31:12]) << 26) | 64'h3FF_FFFF;
            if (longint'(a) >= lo && longint'(a) <= hi) begin found = 1; k = i; end
        end
        if (found) begin
            sw  = 1 << cfg_way[k][11:10];
            cw  = int'(cfg_way[k][9:8]) + 1;
            sg  = gpos(cfg_base[k][5:4]);
            cg  = gpos(cfg_base[k][7:6]);
            off = longint'(cfg_off[k][ch][23:4]) << 26;
            ca  = (longint'(a) - off) & AMASK;
            if (cw == 3 && sg > cg) begin
                t = squeeze(ca, cg, cw, ca);
                r = squeeze(t, sg, sw, t);
            end else begin
                t = squeeze(ca, sg, sw, longint'(a));
                r = squeeze(t, cg, cw, longint'(a));
            end
            e.miss = 1'b0; e.addr = r[ADDR_W-1:0]; e.sw = 4'(sw); e.cw = 3'(cw);
        end
        return e;
    endfunction

    task automatic send(input logic [ADDR_W-1:0] a, input int ch, input string tag, input bit noise);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_chan = 2'(ch);
        sb.push_back(predict(a, ch, tag));
        @(negedge clk);
        in_valid = 1'b0;
        if (noise) begin
            for (int j = 0; j < 6; j++) begin
                if (in_ready) break;
                in_valid = 1'b1;
                in_addr  = a ^ 46'h0000_0F0F_0155;
                in_chan  = 2'(j % CHANS);
                @(negedge clk);
            end
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected result", 64'(out_addr), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_miss == e.miss && out_addr == e.addr && out_sw == e.sw && out_cw == e.cw,
                      e.tag, "result {miss,sw,cw,addr}",
                      {11'd0, out_miss, out_sw, out_cw, out_addr[44:0]},
                      {11'd0, e.miss, e.sw, e.cw, e.addr[44:0]});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cfg_base = '0; cfg_way = '0; cfg_off = '0;
        // e0: 0..3, sock 2 ways @6, chan 3 ways @8 -> socket first
        cfg_base[0] = (32'd0 << 12) | (32'd1 << 6) | (32'd0 << 4);
        cfg_way[0]  = (32'd3 << 12) | (32'd1 << 10) | (32'd2 << 8);
        // e1: 4..7, sock 1 way @12, chan 3 ways @6 -> channel first
        cfg_base[1] = (32'd4 << 12) | (32'd0 << 6) | (32'd2 << 4);
        cfg_way[1]  = (32'd7 << 12) | (32'd0 << 10) | (32'd2 << 8);
        cfg_off[1][1] = 32'd2 << 4;
        cfg_off[1][2] = 32'd1 << 4;
        // e2: 8..11, sock 8 ways @30, chan 4 ways @12
        cfg_base[2] = (32'd8 << 12) | (32'd2 << 6) | (32'd3 << 4);
        cfg_way[2]  = (32'd11 << 12) | (32'd3 << 10) | (32'd3 << 8);
        cfg_off[2][0] = 32'd3 << 4;
        // e3: 12..15, equal granularity @8, chan 3 ways -> socket first
        cfg_base[3] = (32'd12 << 12) | (32'd1 << 6) | (32'd1 << 4);
        cfg_way[3]  = (32'd15 << 12) | (32'd0 << 10) | (32'd2 << 8);
        // e4 16..19 overlaps e5 16..23
        cfg_base[4] = (32'd16 << 12) | (32'd0 << 6) | (32'd1 << 4);
        cfg_way[4]  = (32'd19 << 12) | (32'd1 << 10) | (32'd0 << 8);
        cfg_base[5] = (32'd16 << 12) | (32'd2 << 6) | (32'd0 << 4);
        cfg_way[5]  = (32'd23 << 12) | (32'd2 << 10) | (32'd1 << 8);
        // e6, e7 empty windows
        cfg_base[6] = 32'hFFFFF << 12; cfg_way[6] = 32'd0;
        cfg_base[7] = 32'hFFFFF << 12; cfg_way[7] = 32'd0;

        in_valid = 1'b0; in_addr = '0; in_chan = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "in_ready after reset", 64'(in_ready), 1);
        check(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 0);

        send(46'h0000_0000_0000, 0, "R1", 1'b0);   // window base
        send(46'h0000_0ABC_DEF5, 0, "R7", 1'b0);
        send(46'h0000_0FFF_FFFF, 0, "R1", 1'b0);   // window limit
        send(46'h0000_1234_5678, 0, "R6", 1'b1);   // busy inputs ignored too (R9)
        send(46'h0000_1ABC_DE01, 1, "R4", 1'b0);
        send(46'h0000_1ABC_DE01, 2, "R4", 1'b0);
        send(46'h0000_1FFF_FFFF, 1, "R10", 1'b1);
        send(46'h0000_2F0F_1234, 0, "R3", 1'b0);
        send(46'h0000_2345_6789, 1, "R2", 1'b0);
        send(46'h0000_3777_7777, 0, "R7", 1'b0);
        send(46'h0000_4123_4567, 0, "R1", 1'b0);   // overlap: lowest index
        send(46'h0000_5555_5555, 2, "R1", 1'b0);
        send(46'h0000_6000_0005, 0, "R8", 1'b0);
        send(46'h3FFF_FFFF_FFFF, 1, "R8", 1'b0);   // back-to-back misses
        send(46'h0000_0777_7777, 1, "R5", 1'b0);
        send(46'h0000_1555_5555, 0, "R10", 1'b0);

        while (sb.size() != 0 || !in_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R9", "results outstanding", 64'(sb.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule